// File: doc/BRIEF.md
# Card Clock Divider Generator

This block derives the clock that is driven to a memory card from the block's master clock. A single configuration word selects the behaviour. Software supplies an 8-bit divide value and picks one of two divide laws. A bypass bit hands the master clock through undivided. The word also holds an enable bit, a power-save bit that stops the clock while neither the command path nor the data path is busy, and two bits that indicate bus width. When hardware flow control is enabled, the data FIFO can stall the card clock by asserting a stall request.

The command and data paths use the card-clock edge strobe. It is high for exactly the master cycle in which the card clock rises, so those paths can stay in the master clock domain. A change to the divide value is taken up at the next card-clock edge. The clock never produces a shortened high pulse, and whenever it is gated or stopped it rests low.

Configuration word layout: bits [7:0] divide value N; bit 8 enable; bit 9 power save; bit 10 bypass; bit 11 4-bit bus; bit 12 8-bit bus; bit 15 alternate law. The flow-control enable sits at bit 13 by default, or at bit 14 when parameter `HWFC_BIT` is 14.

Top module: `card_clk_gen`

## Requirements
- R1: While reset is asserted and in the cycle after it, the card clock and the strobe are low and the bus-width output reads 2'b00.
- R2: In standard law (bit 15 clear) the card clock period is 2*(N+1) master cycles, with N+1 cycles high and N+1 cycles low.
- R3: In alternate law (bit 15 set) the period is N+2 master cycles: floor((N+2)/2) cycles high and ceil((N+2)/2) cycles low.
- R4: With N=255 in standard law the card clock runs at the lowest rate, one card period every 512 master cycles.
- R5: With bypass (bit 10) and enable set, the card clock is high while the master clock is high and low while it is low, and the strobe is high in every master cycle.
- R6: With enable (bit 8) clear, the card clock stays low and makes no edges, whatever the other bits hold.
- R7: With the flow-control bit set, a stall request stops the card clock low. Without that bit, stall is ignored. In the default build, bit 14 has no effect on stalling.
- R8: With power save (bit 9) set, the card clock toggles only while path_busy_i is high.
- R9: A new divide value takes effect at the next card clock edge. A high phase already under way completes at its old length, and no high pulse is ever cut short.
- R10: bus_width_o, registered one cycle after the configuration, reads 2'b01 for bit 11 alone, 2'b10 whenever bit 12 is set, and 2'b00 otherwise.
- R11: In divided mode the strobe is high in exactly the master cycle of each card clock rising edge and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| clk_cfg_i | input | 16 | Clock configuration word |
| fifo_stall_i | input | 1 | FIFO request to stall the card clock |
| path_busy_i | input | 1 | Command or data path active, used by power save |
| card_clk_o | output | 1 | Card clock |
| card_stb_o | output | 1 | Card clock rising-edge strobe |
| bus_width_o | output | 2 | Decoded bus width (00 one bit, 01 four, 10 eight) |

## Verification
A new divide value can arrive in the same master cycle as a card clock rising edge. That cycle is where the phase-length reload and the configuration update meet. The bench waits until it sees a rising edge, then rewrites N from 7 to 1 before the next master edge. It expects the period it measures next to be eight cycles high followed by two cycles low. A stall request or a power-save stop can also arrive during a high phase. For that case, assertions check that the high phase still runs to its full length before the clock rests low.

// File: rtl/ccg_pkg.sv
// Shared constants and types for the card clock generator.
// Assumes a 16-bit configuration word with the field positions below.
package ccg_pkg;
    localparam int F_EN    = 8;
    localparam int F_PSAVE = 9;
    localparam int F_BYP   = 10;
    localparam int F_W4    = 11;
    localparam int F_W8    = 12;
    localparam int F_ALT   = 15;

    typedef enum logic [1:0] {
        BW_1 = 2'b00,
        BW_4 = 2'b01,
        BW_8 = 2'b10
    } bus_w_e;
endpackage

// File: rtl/ccg_ctrl.sv
// Decodes the configuration word into divide value, law, run and
// bypass controls, and registers the bus-width indication.
// Assumes HWFC_BIT is 13 or 14; the other of the two bits is spare.
module ccg_ctrl
    import ccg_pkg::*;
#(
    parameter int CFG_W    = 16,
    parameter int DIV_W    = 8,
    parameter int HWFC_BIT = 13
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             stall_i,
    input  logic             busy_i,
    output logic [DIV_W-1:0] div_o,
    output logic             alt_o,
    output logic             div_go_o,
    output logic             byp_open_o,
    output bus_w_e           width_o
);
    localparam int SPARE_BIT = (HWFC_BIT == 14) ? 13 : 14;

    logic hwfc;
    logic run;
    logic cfg_unused;

    assign hwfc       = cfg_i[HWFC_BIT];
    assign cfg_unused = cfg_i[SPARE_BIT];
    assign div_o      = cfg_i[DIV_W-1:0];
    assign alt_o      = cfg_i[F_ALT];

    // Card clock may run: enabled, not stalled by the FIFO, not parked by power save.
    always_comb begin
        run        = cfg_i[F_EN] && !(hwfc && stall_i) && !(cfg_i[F_PSAVE] && !busy_i);
        div_go_o   = run && !cfg_i[F_BYP];
        byp_open_o = run && cfg_i[F_BYP];
    end

    // Bus width indication, 8-bit taking precedence over 4-bit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)             width_o <= BW_1;
        else if (cfg_i[F_W8])    width_o <= BW_8;
        else if (cfg_i[F_W4])    width_o <= BW_4;
        else                     width_o <= BW_1;
    end

    a_r10_width_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        width_o != 2'b11);
endmodule

// File: rtl/ccg_divider.sv
// Divided card clock: phase counter reloaded at each card edge from the
// live divide value, so a new value applies from the next edge on.
// Assumes go_i already folds in enable, stall, power save and bypass.
module ccg_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    input  logic             alt_i,
    input  logic             go_i,
    output logic             div_clk_o,
    output logic             rise_o
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] wide_n;
    logic [CNT_W-1:0] hi_len;
    logic [CNT_W-1:0] lo_len;
    logic [CNT_W-1:0] cnt_q;

    assign wide_n = {1'b0, div_i};

    // Phase lengths for the selected divide law.
    always_comb begin
        if (alt_i) begin
            hi_len = (wide_n + CNT_W'(2)) >> 1;
            lo_len = (wide_n + CNT_W'(3)) >> 1;
        end else begin
            hi_len = wide_n + CNT_W'(1);
            lo_len = wide_n + CNT_W'(1);
        end
    end

    // Phase counter and output toggle; rising only when allowed to run.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            div_clk_o <= 1'b0;
            rise_o    <= 1'b0;
            cnt_q     <= '0;
        end else begin
            rise_o <= 1'b0;
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end else if (div_clk_o) begin
                div_clk_o <= 1'b0;
                cnt_q     <= lo_len - CNT_W'(1);
            end else if (go_i) begin
                div_clk_o <= 1'b1;
                rise_o    <= 1'b1;
                cnt_q     <= hi_len - CNT_W'(1);
            end
        end
    end

    a_r11_strobe_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(div_clk_o) |-> rise_o);
    a_r11_strobe_only_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |-> (div_clk_o && !$past(div_clk_o)));
    a_r9_no_runt: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_clk_o && cnt_q != '0) |=> div_clk_o);
    a_r2_fall_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_clk_o && cnt_q == '0) |=> !div_clk_o);
    a_r6_rest_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!div_clk_o && !go_i) |=> !div_clk_o);
endmodule

// File: rtl/ccg_bypass_gate.sv
// Glitch-free gate for passing the master clock straight through.
// The enable changes only while the master clock is low, and it opens
// only when the divided clock is resting low.
module ccg_bypass_gate (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic open_i,
    input  logic div_clk_i,
    output logic gate_o
);
    // Gate enable captured on the falling master edge.
    always_ff @(negedge clk_i) begin
        if (!rst_ni) gate_o <= 1'b0;
        else         gate_o <= open_i && !div_clk_i;
    end
endmodule

// File: rtl/card_clk_gen.sv
// Card clock generator top: configuration decode, divided clock,
// bypass gate, and merging of the two into the card clock and strobe.
// Assumes the configuration word is stable around the falling edge.
module card_clk_gen
    import ccg_pkg::*;
#(
    parameter int CFG_W    = 16,
    parameter int DIV_W    = 8,
    parameter int HWFC_BIT = 13
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CFG_W-1:0] clk_cfg_i,
    input  logic             fifo_stall_i,
    input  logic             path_busy_i,
    output logic             card_clk_o,
    output logic             card_stb_o,
    output logic [1:0]       bus_width_o
);
    logic [DIV_W-1:0] div_val;
    logic             alt_law;
    logic             div_go;
    logic             byp_open;
    logic             div_clk;
    logic             div_rise;
    logic             gate;
    bus_w_e           width;

    ccg_ctrl #(.CFG_W(CFG_W), .DIV_W(DIV_W), .HWFC_BIT(HWFC_BIT)) u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cfg_i      (clk_cfg_i),
        .stall_i    (fifo_stall_i),
        .busy_i     (path_busy_i),
        .div_o      (div_val),
        .alt_o      (alt_law),
        .div_go_o   (div_go),
        .byp_open_o (byp_open),
        .width_o    (width)
    );

    ccg_divider #(.DIV_W(DIV_W)) u_div (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .div_i     (div_val),
        .alt_i     (alt_law),
        .go_i      (div_go),
        .div_clk_o (div_clk),
        .rise_o    (div_rise)
    );

    ccg_bypass_gate u_gate (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .open_i    (byp_open),
        .div_clk_i (div_clk),
        .gate_o    (gate)
    );

    // Merge divided clock with the gated master clock.
    always_comb begin
        card_clk_o  = div_clk | (clk_i & gate);
        card_stb_o  = div_rise | gate;
        bus_width_o = width;
    end

    a_r5_paths_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_rise |-> !gate);
endmodule

// File: tb/card_clk_gen_test.sv
module card_clk_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg = 16'h0;
    logic        stall = 1'b0;
    logic        busy = 1'b0;
    logic        card_clk;
    logic        card_stb;
    logic [1:0]  bus_width;

    int checks = 0;
    int fails = 0;
    int done_cnt = 0;

    typedef struct { int hi; int lo; string req; } exp_t;
    exp_t expq[$];

    localparam logic [15:0] EN = 16'h0100, PS = 16'h0200, BYP = 16'h0400,
        W4 = 16'h0800, W8 = 16'h1000, FC = 16'h2000, B14 = 16'h4000, ALT = 16'h8000;

    card_clk_gen uut (
        .clk_i(clk), .rst_ni(rst_n), .clk_cfg_i(cfg), .fifo_stall_i(stall),
        .path_busy_i(busy), .card_clk_o(card_clk), .card_stb_o(card_stb),
        .bus_width_o(bus_width)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // Monitor: measures each card period and compares against the queue.
    initial begin : monitor
        bit prev = 1'b0;
        bit have = 1'b0;
        bit chk_next = 1'b0;
        int hi = 0, lo = 0;
        exp_t cur;
        forever begin
            tick();
            if (card_clk && !prev) begin
                if (have) begin
                    chk(hi == cur.hi, {cur.req, " high cycles"}, hi, cur.hi);
                    chk(lo == cur.lo, {cur.req, " low cycles"}, lo, cur.lo);
                    have = 1'b0;
                    done_cnt++;
                end
                if (expq.size() > 0) begin
                    cur = expq.pop_front();
                    have = 1'b1;
                    chk(card_stb == 1'b1, "R11 strobe at rise", card_stb, 1);
                    chk_next = 1'b1;
                end
                hi = 1; lo = 0;
            end else begin
                if (chk_next) begin
                    chk(card_stb == 1'b0, "R11 strobe after rise", card_stb, 0);
                    chk_next = 1'b0;
                end
                if (card_clk) hi++; else lo++;
            end
            prev = card_clk;
        end
    end

    // Driver side: queue one expected period and wait for its comparison.
    task automatic expect_period(input int hi, input int lo, input string req);
        int target;
        exp_t e;
        e.hi = hi; e.lo = lo; e.req = req;
        target = done_cnt + 1;
        expq.push_back(e);
        wait (done_cnt == target);
    endtask

    task automatic set_cfg(input logic [15:0] v, input int settle);
        cfg = v;
        repeat (settle) tick();
    endtask

    task automatic activity(input int n, output int rises, output int highs);
        bit prev = card_clk;
        rises = 0; highs = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (card_clk) highs++;
            if (card_clk && !prev) rises++;
            prev = card_clk;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : driver
        int r, h;
        // R1 reset state
        repeat (4) tick();
        chk(card_clk == 0, "R1 card clock in reset", card_clk, 0);
        chk(card_stb == 0, "R1 strobe in reset", card_stb, 0);
        chk(bus_width == 2'b00, "R1 width in reset", bus_width, 0);
        rst_n = 1'b1;
        tick();
        chk(card_clk == 0 && card_stb == 0, "R1 after reset", card_clk, 0);

        // R6 enable clear: no edges
        set_cfg(16'h0003 | W4, 2);
        activity(600, r, h);
        chk(h == 0, "R6 disabled clock stays low", h, 0);

        // R2 standard law
        set_cfg(EN | 16'd0, 8);
        expect_period(1, 1, "R2 N=0");
        set_cfg(EN | 16'd3, 20);
        expect_period(4, 4, "R2 N=3");
        // R4 slowest rate
        set_cfg(EN | 16'd255, 1100);
        expect_period(256, 256, "R4 N=255");

        // R3 alternate law
        set_cfg(EN | ALT | 16'd0, 1100);
        expect_period(1, 1, "R3 N=0");
        set_cfg(EN | ALT | 16'd1, 8);
        expect_period(1, 2, "R3 N=1");
        set_cfg(EN | ALT | 16'd4, 16);
        expect_period(3, 3, "R3 N=4");
        set_cfg(EN | ALT | 16'd255, 20);
        expect_period(128, 129, "R3 N=255");

        // R9 divide change on a rising edge: old high length, new low length
        set_cfg(EN | 16'd7, 600);
        while (card_clk !== 1'b1) tick();
        while (card_clk !== 1'b0) tick();
        expq.push_back('{hi: 8, lo: 2, req: "R9 change at rise"});
        while (card_clk !== 1'b1) tick();
        #1 cfg = EN | 16'd1;
        wait (done_cnt > 0 && expq.size() == 0);
        repeat (30) tick();
        expect_period(2, 2, "R9 new value settled");

        // R7 flow control
        stall = 1'b1;
        set_cfg(EN | FC | 16'd3, 20);
        activity(50, r, h);
        chk(h == 0, "R7 stall stops clock low", h, 0);
        set_cfg(EN | 16'd3, 2);
        activity(50, r, h);
        chk(r >= 5, "R7 stall ignored without flow control", r, 6);
        set_cfg(EN | B14 | 16'd3, 2);
        activity(50, r, h);
        chk(r >= 5, "R7 bit 14 has no effect", r, 6);
        stall = 1'b0;
        set_cfg(EN | FC | 16'd3, 20);
        expect_period(4, 4, "R7 resume after stall");

        // R8 power save
        busy = 1'b0;
        set_cfg(EN | PS | 16'd3, 20);
        activity(50, r, h);
        chk(h == 0, "R8 idle paths park clock", h, 0);
        busy = 1'b1;
        repeat (20) tick();
        expect_period(4, 4, "R8 busy runs clock");
        busy = 1'b0;

        // R5 bypass
        set_cfg(16'h0000, 20);
        set_cfg(EN | BYP, 5);
        begin
            int hi_ok = 0, lo_ok = 0, st_ok = 0;
            for (int i = 0; i < 10; i++) begin
                @(posedge clk); #1;
                if (card_clk) hi_ok++;
                if (card_stb) st_ok++;
                @(negedge clk); #1;
                if (!card_clk) lo_ok++;
            end
            chk(hi_ok == 10, "R5 bypass high with master", hi_ok, 10);
            chk(lo_ok == 10, "R5 bypass low with master", lo_ok, 10);
            chk(st_ok == 10, "R5 bypass strobe every cycle", st_ok, 10);
        end
        stall = 1'b1;
        set_cfg(EN | BYP | FC, 5);
        activity(20, r, h);
        chk(h == 0, "R7 bypass stalled rests low", h, 0);
        stall = 1'b0;

        // R10 bus width
        set_cfg(W4, 1);
        chk(bus_width == 2'b01, "R10 four-bit", bus_width, 1);
        set_cfg(W8, 1);
        chk(bus_width == 2'b10, "R10 eight-bit", bus_width, 2);
        set_cfg(W4 | W8, 1);
        chk(bus_width == 2'b10, "R10 both set", bus_width, 2);
        set_cfg(16'h0, 1);
        chk(bus_width == 2'b00, "R10 one-bit", bus_width, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule